// File: doc/BRIEF.md
# Pin Edge/Level Interrupt Controller

This block watches eight asynchronous input lines and turns qualifying activity on each line into a per-line interrupt request. Every line has its own five-bit mode code. The code chooses between edge detection (rising, falling or both) and level detection (low or high), or it turns the line off. Two flag vectors record rising and falling edges separately from the request status. A status clear affects only lines that are in edge mode. A line in level mode requests for as long as its level qualifies.

Software writes modes and clear masks through a single-cycle write port that has an enable, an address and data. It reads modes, flags and status through a combinational read port. Each line drives one request output, and that output equals its status bit.

Address map: 0x0 to 0x7 hold the mode of line 0 to line 7 in data bits [4:0]. 0x8 holds the rise flags, 0x9 the fall flags and 0xA the status. Each of these three vectors is write-one-to-clear, bit n for line n. Unmapped addresses read as zero.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset all modes read 0, the rise flags, fall flags and status read 0, and irq is 0.
- R2: A write to address n (0 to 7) stores data bits [4:0] as the mode of line n. Bit 4 selects level (1) or edge (0). Bit 0 enables rising edges. Bit 1 means falling edge in edge mode and high level in level mode. Reads return the stored value zero-extended.
- R3: Each input passes through a two-flop synchronizer. A level-mode request follows an input change after two clock edges. An edge-mode request is set on the third clock edge.
- R4: In rising mode (0x01) a 0-to-1 input transition sets the line's request. The request stays set through later input changes until it is cleared.
- R5: Falling mode (0x02) sets the request only on 1-to-0 transitions. Both-edges mode (0x03) sets it on either transition.
- R6: Low-level mode (0x10) and high-level mode (0x12) assert the request while the synchronized input is at the qualifying level and drop it when the level leaves.
- R7: A rising edge sets rise flag n (address 0x8) when line n is in edge mode with bit 0 set. A falling edge sets fall flag n (address 0x9) when line n is in edge mode with bit 1 set. Writing 1 to a flag bit clears only that bit.
- R8: Writing 1 to status bit n (address 0xA) clears a line that is in edge mode. The write has no effect on a line that is in level mode.
- R9: If a qualifying edge arrives in the same cycle as a clear write to that line, the bit stays set.
- R10: A line with mode 0x00 never raises its request, its rise flag or its fall flag.
- R11: Writing all ones (0xFF) to 0x8, 0x9 and 0xA clears every rise flag, every fall flag and every edge-mode request.
- R12: Lines are independent. Activity on one line does not change another line's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 8 | Asynchronous monitored lines |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data or clear mask |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Combinational read data |
| irq | output | 8 | Per-line interrupt request |

## Verification
Each mode is driven with both input transitions, so the test can tell rising, falling and both-edge detection apart. The level modes are driven in and out of their qualifying level, which separates level following from sticky edge capture. Clear writes are sent to edge lines and to level lines, which shows that clears are qualified by mode. One clear write is timed to land in the same cycle as a fresh edge to check that the edge takes precedence. An input step is traced edge by edge to confirm the two-flop latency. Mode 0x00 lines and untouched neighbour lines are also checked, to show that neither reacts to activity elsewhere.

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
  parameter int N  = 8,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pin_in,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [N-1:0]  irq
);
  localparam int MW = 5;
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [AW-1:0] A_RISE = AW'(N);
  localparam logic [AW-1:0] A_FALL = AW'(N + 1);
  localparam logic [AW-1:0] A_STAT = AW'(N + 2);

  logic [N-1:0] s1, s2, s3;
  logic [MW-1:0] mode [N];
  logic [N-1:0] ren, fen, edge_m, lvl_q;
  logic [N-1:0] rise_flg, fall_flg, sticky;
  logic [N-1:0] rise_clr, fall_clr, st_clr;
  logic [N-1:0] rise_det, fall_det;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
    end

  assign rise_det = s2 & ~s3;
  assign fall_det = ~s2 & s3;

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) mode[i] <= '0;
      else if (wr_en && wr_addr == AW'(i)) mode[i] <= wr_data[MW-1:0];
    assign ren[i]   = ~mode[i][4] & mode[i][0];
    assign fen[i]   = ~mode[i][4] & mode[i][1];
    assign lvl_q[i] = mode[i][4] & (mode[i][1] ? s2[i] : ~s2[i]);
  end

  assign edge_m   = ren | fen;
  assign rise_clr = (wr_en && wr_addr == A_RISE) ? wr_data[N-1:0] : '0;
  assign fall_clr = (wr_en && wr_addr == A_FALL) ? wr_data[N-1:0] : '0;
  assign st_clr   = (wr_en && wr_addr == A_STAT) ? wr_data[N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rise_flg <= '0;
      fall_flg <= '0;
      sticky   <= '0;
    end else begin
      rise_flg <= (rise_flg & ~rise_clr) | (rise_det & ren);
      fall_flg <= (fall_flg & ~fall_clr) | (fall_det & fen);
      sticky   <= ((sticky & ~st_clr) | (rise_det & ren) | (fall_det & fen)) & edge_m;
    end

  assign irq = sticky | lvl_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr < AW'(N))      rd_data = DW'(mode[rd_addr[IW-1:0]]);
    else if (rd_addr == A_RISE) rd_data = DW'(rise_flg);
    else if (rd_addr == A_FALL) rd_data = DW'(fall_flg);
    else if (rd_addr == A_STAT) rd_data = DW'(irq);
  end

  // R7
  rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_flg & $past(rise_flg & ~rise_clr)) == $past(rise_flg & ~rise_clr)));
  // R7
  fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fall_flg & $past(fall_flg & ~fall_clr)) == $past(fall_flg & ~fall_clr)));
  // R4
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_flg & ~$past(rise_flg) & ~$past(s2 & ~s3)) == '0));
  // R5
  sticky_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky & ~$past(sticky) & ~$past(s2 ^ s3)) == '0));
  // R10
  no_edge_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky & ~$past(edge_m)) == '0));
endmodule

// File: tb/test_pin_irq_ctrl.sv
module test_pin_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic [7:0] pins = '0;
  logic wr_en = 0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pin_irq_ctrl i_pin_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic setp(int i, logic v);
    @(negedge clk);
    pins[i] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), v);
      check("R1 reg", v, 0);
    end
    check("R1 irq", irq, 0);
  endtask

  task automatic t_mode_rw();
    logic [7:0] v;
    wr(4'd3, 8'h12); rd(4'd3, v); check("R2 mode3", v, 8'h12);
    wr(4'd5, 8'hFF); rd(4'd5, v); check("R2 mode5 width", v, 8'h1F);
    wr(4'd3, 8'h00); wr(4'd5, 8'h00);
    rd(4'd3, v); check("R2 mode3 restore", v, 0);
  endtask

  task automatic t_rise();
    logic [7:0] v;
    wr(4'd0, 8'h01);
    setp(0, 1);
    check("R4 rise irq", irq[0], 1);
    rd(4'd8, v); check("R7 rise flag", v, 8'h01);
    setp(0, 0);
    check("R4 sticky", irq[0], 1);
    rd(4'd9, v); check("R7 no fall flag in rise mode", v, 0);
    wr(4'd10, 8'h01);
    check("R8 edge clear", irq[0], 0);
    wr(4'd8, 8'h01); rd(4'd8, v); check("R7 w1c rise", v, 0);
  endtask

  task automatic t_fall_both();
    logic [7:0] v;
    wr(4'd1, 8'h02); wr(4'd2, 8'h03);
    setp(1, 1);
    check("R5 fall ignores rise", irq[1], 0);
    setp(1, 0);
    check("R5 fall irq", irq[1], 1);
    check("R12 neighbour quiet", irq[2], 0);
    rd(4'd9, v); check("R7 fall flag", v, 8'h02);
    wr(4'd9, 8'h02); rd(4'd9, v); check("R7 w1c fall", v, 0);
    wr(4'd10, 8'h02);
    setp(2, 1);
    check("R5 both rise", irq[2], 1);
    check("R12 line1 unaffected", irq[1], 0);
    wr(4'd10, 8'h04);
    check("R8 clear both", irq[2], 0);
    setp(2, 0);
    check("R5 both fall", irq[2], 1);
    wr(4'd10, 8'h04); wr(4'd8, 8'hFF); wr(4'd9, 8'hFF);
  endtask

  task automatic t_level();
    wr(4'd4, 8'h12);
    check("R6 high idle", irq[4], 0);
    setp(4, 1);
    check("R6 high active", irq[4], 1);
    wr(4'd10, 8'h10);
    check("R8 level ignores clear", irq[4], 1);
    setp(4, 0);
    check("R6 high released", irq[4], 0);
    wr(4'd5, 8'h10);
    check("R6 low active", irq[5], 1);
    setp(5, 1);
    check("R6 low released", irq[5], 0);
    setp(5, 0);
  endtask

  task automatic t_latency();
    wr(4'd6, 8'h12); wr(4'd7, 8'h01);
    @(negedge clk); pins[6] = 1; pins[7] = 1;
    @(negedge clk);
    check("R3 level 1 edge", irq[6], 0);
    @(negedge clk);
    check("R3 level 2 edges", irq[6], 1);
    check("R3 edge 2 edges", irq[7], 0);
    @(negedge clk);
    check("R3 edge 3 edges", irq[7], 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    @(negedge clk); pins[0] = 1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'd10; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 0;
    check("R9 edge beats clear", irq[0], 1);
    repeat (3) @(negedge clk);
    rd(4'd8, v); check("R9 flag set", v[0], 1);
  endtask

  task automatic t_none();
    logic [7:0] v;
    setp(3, 1); setp(3, 0);
    check("R10 none irq", irq[3], 0);
    rd(4'd8, v); check("R10 none rise", v[3], 0);
    rd(4'd9, v); check("R10 none fall", v[3], 0);
  endtask

  task automatic t_clear_all();
    logic [7:0] v;
    setp(1, 1); setp(1, 0);
    wr(4'd8, 8'hFF); wr(4'd9, 8'hFF); wr(4'd10, 8'hFF);
    rd(4'd8, v); check("R11 rise all", v, 0);
    rd(4'd9, v); check("R11 fall all", v, 0);
    check("R11 edge irq", irq & 8'h87, 0);
    check("R11 level kept", irq & 8'h70, 8'h60);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mode_rw();
    t_rise();
    t_fall_both();
    t_level();
    t_latency();
    t_collide();
    t_none();
    t_clear_all();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule